// File: doc/BRIEF.md
# Inter-Processor Doorbell Mailbox

This block passes work between a host processor and a coprocessor. Each side has its own read/write port into the same four 32-bit registers. The host stores the address of a request descriptor in its message register. It then rings a doorbell flag, which interrupts the coprocessor. The coprocessor raises an early acknowledge as soon as it has taken the request. When the work is finished, it stores a reply address in its own message register and raises a reply-ready flag. Both the acknowledge and reply-ready flags can interrupt the host, each under its own enable.

Every flag is changed only by pulse writes: a 1 in a given bit position sets or clears that flag, and a 0 leaves it alone. As a result, neither side can disturb a flag that the other side owns just by rewriting a control word. When a set and a clear of the same flag arrive in the same cycle, the set takes effect, so no event is lost. Descriptors are 32-byte aligned, so the low five bits of each message register are always stored as zero.

Top module: `ipc_doorbell`

## Requirements
- R1: After reset, all four registers read as zero on both ports, and both interrupt lines are low.
- R2: A host write to register index 0 (byte offset 0x0) stores the write data with bits 4:0 forced to zero. The new value is visible from the following cycle.
- R3: A coprocessor write to register index 2 (offset 0x8) stores the write data with bits 4:0 forced to zero. The new value is visible from the following cycle.
- R4: A host write to index 1 (offset 0x4) with bit 0 set raises the doorbell flag. `copIrq` is high from the next cycle and stays high for as long as the doorbell flag is set.
- R5: A coprocessor write to index 3 (offset 0xC) with bit 0 set clears the doorbell flag.
- R6: A coprocessor write to index 3 sets the acknowledge flag when bit 1 is 1, and sets the reply-ready flag when bit 2 is 1.
- R7: A host write to index 1 clears the acknowledge flag when bit 1 is 1, and clears the reply-ready flag when bit 2 is 1. A 0 in any flag bit leaves that flag unchanged.
- R8: Every host write to index 1 loads bit 4 as the reply-ready interrupt enable and bit 5 as the acknowledge interrupt enable. `hostIrq` equals (reply-ready AND its enable) OR (acknowledge AND its enable).
- R9: If one side sets a flag in the same cycle that the other side clears it, the flag ends up set.
- R10: Indices 1 and 3 both read back the same status word: bit 0 doorbell, bit 1 acknowledge, bit 2 reply-ready, bit 4 reply-ready enable, bit 5 acknowledge enable. All other bits read as zero.
- R11: Writes from the host to indices 2 or 3, and writes from the coprocessor to indices 0 or 1, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe |
| hostAddr | input | 2 | Host register index (byte offset divided by 4) |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data for `hostAddr`, combinational |
| copWrEn | input | 1 | Coprocessor write strobe |
| copAddr | input | 2 | Coprocessor register index |
| copWrData | input | 32 | Coprocessor write data |
| copRdData | output | 32 | Coprocessor read data for `copAddr`, combinational |
| copIrq | output | 1 | Interrupt toward the coprocessor (doorbell pending) |
| hostIrq | output | 1 | Interrupt toward the host (enabled acknowledge or reply) |

## Verification
The assertions assume that the write strobes and addresses are never unknown, and that each port makes at most one write per cycle. They also assume that both strobes stay low while reset is held, since an interrupt rising right after reset is traced back to a strobe in the previous cycle. The bench drives every input on the falling clock edge and holds both strobes low throughout reset. A directed handshake and collision sequence is followed by a long pseudo-random sweep that hits every index from both sides with arbitrary data, including the illegal cross-side writes.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int RSEL_W = 2;
  localparam logic [RSEL_W-1:0] REG_HOST_MSG = 2'd0;
  localparam logic [RSEL_W-1:0] REG_HOST_CTL = 2'd1;
  localparam logic [RSEL_W-1:0] REG_COP_MSG  = 2'd2;
  localparam logic [RSEL_W-1:0] REG_COP_CTL  = 2'd3;

  localparam int BIT_DOORBELL = 0;
  localparam int BIT_ACK      = 1;
  localparam int BIT_REPLY    = 2;
  localparam int BIT_REPLY_EN = 4;
  localparam int BIT_ACK_EN   = 5;
  localparam int FLAG_W       = 3;

  typedef struct packed {
    logic hostMsgWr;
    logic copMsgWr;
    logic setBell;
    logic clrBell;
    logic setAck;
    logic clrAck;
    logic setReply;
    logic clrReply;
    logic enWr;
  } ipcStrobes_t;
endpackage

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
  import ipc_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic [RSEL_W-1:0]   hostAddr,
  input  logic [FLAG_W-1:0]   hostFlagBits,
  input  logic                copWrEn,
  input  logic [RSEL_W-1:0]   copAddr,
  input  logic [FLAG_W-1:0]   copFlagBits,
  output ipcStrobes_t         stb
);
  logic hostCtl, copCtl;

  always_comb begin
    hostCtl      = hostWrEn && (hostAddr == REG_HOST_CTL);
    copCtl       = copWrEn  && (copAddr  == REG_COP_CTL);
    stb          = '0;
    stb.hostMsgWr = hostWrEn && (hostAddr == REG_HOST_MSG);
    stb.copMsgWr  = copWrEn  && (copAddr  == REG_COP_MSG);
    stb.enWr      = hostCtl;
    stb.setBell   = hostCtl && hostFlagBits[BIT_DOORBELL];
    stb.clrAck    = hostCtl && hostFlagBits[BIT_ACK];
    stb.clrReply  = hostCtl && hostFlagBits[BIT_REPLY];
    stb.clrBell   = copCtl  && copFlagBits[BIT_DOORBELL];
    stb.setAck    = copCtl  && copFlagBits[BIT_ACK];
    stb.setReply  = copCtl  && copFlagBits[BIT_REPLY];
  end

  // R11: an idle port produces none of its strobes
  assert_host_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !hostWrEn |-> !(stb.hostMsgWr || stb.setBell || stb.clrAck || stb.clrReply || stb.enWr));
  assert_cop_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    !copWrEn |-> !(stb.copMsgWr || stb.clrBell || stb.setAck || stb.setReply));
endmodule

// File: rtl/ipc_datapath.sv
module ipc_datapath
  import ipc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  ipcStrobes_t         stb,
  input  logic [DATA_W-1:0]   hostWrData,
  input  logic [DATA_W-1:0]   copWrData,
  input  logic [RSEL_W-1:0]   hostAddr,
  input  logic [RSEL_W-1:0]   copAddr,
  output logic [DATA_W-1:0]   hostRdData,
  output logic [DATA_W-1:0]   copRdData,
  output logic                hostIrq,
  output logic                copIrq
);
  localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));
  localparam int NUM_PORTS = 2;

  logic [DATA_W-1:0] hostMsg, copMsg, statusWord;
  logic bellFlag, ackFlag, replyFlag, replyEn, ackEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostMsg   <= '0;
      copMsg    <= '0;
      bellFlag  <= 1'b0;
      ackFlag   <= 1'b0;
      replyFlag <= 1'b0;
      replyEn   <= 1'b0;
      ackEn     <= 1'b0;
    end else begin
      if (stb.hostMsgWr) hostMsg <= hostWrData & ALIGN_MASK;
      if (stb.copMsgWr)  copMsg  <= copWrData & ALIGN_MASK;
      // set has priority over a clear in the same cycle
      if (stb.setBell)       bellFlag <= 1'b1;
      else if (stb.clrBell)  bellFlag <= 1'b0;
      if (stb.setAck)        ackFlag <= 1'b1;
      else if (stb.clrAck)   ackFlag <= 1'b0;
      if (stb.setReply)      replyFlag <= 1'b1;
      else if (stb.clrReply) replyFlag <= 1'b0;
      if (stb.enWr) begin
        replyEn <= hostWrData[BIT_REPLY_EN];
        ackEn   <= hostWrData[BIT_ACK_EN];
      end
    end
  end

  always_comb begin
    statusWord               = '0;
    statusWord[BIT_DOORBELL] = bellFlag;
    statusWord[BIT_ACK]      = ackFlag;
    statusWord[BIT_REPLY]    = replyFlag;
    statusWord[BIT_REPLY_EN] = replyEn;
    statusWord[BIT_ACK_EN]   = ackEn;
  end

  logic [RSEL_W-1:0] rdSel  [NUM_PORTS];
  logic [DATA_W-1:0] rdWord [NUM_PORTS];
  assign rdSel[0] = hostAddr;
  assign rdSel[1] = copAddr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_readPort
    always_comb begin
      case (rdSel[p])
        REG_HOST_MSG: rdWord[p] = hostMsg;
        REG_COP_MSG:  rdWord[p] = copMsg;
        default:      rdWord[p] = statusWord;
      endcase
    end
  end

  assign hostRdData = rdWord[0];
  assign copRdData  = rdWord[1];
  assign copIrq     = bellFlag;
  assign hostIrq    = (replyFlag && replyEn) || (ackFlag && ackEn);

  assert_bell_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.setBell |=> copIrq);
  assert_bell_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrBell && !stb.setBell) |=> !copIrq);
  assert_reply_set_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.setReply |=> replyFlag);
  assert_ack_set_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setAck && stb.clrAck) |=> ackFlag);
  assert_host_msg_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !stb.hostMsgWr |=> $stable(hostMsg));
  assert_cop_msg_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.copMsgWr |=> $stable(copMsg));
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostIrq) |-> $past(stb.setAck || stb.setReply || stb.enWr));
endmodule

// File: rtl/ipc_doorbell.sv
module ipc_doorbell
  import ipc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostWrEn,
  input  logic [RSEL_W-1:0]   hostAddr,
  input  logic [DATA_W-1:0]   hostWrData,
  output logic [DATA_W-1:0]   hostRdData,
  input  logic                copWrEn,
  input  logic [RSEL_W-1:0]   copAddr,
  input  logic [DATA_W-1:0]   copWrData,
  output logic [DATA_W-1:0]   copRdData,
  output logic                copIrq,
  output logic                hostIrq
);
  ipcStrobes_t stb;

  ipc_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostWrEn     (hostWrEn),
    .hostAddr     (hostAddr),
    .hostFlagBits (hostWrData[FLAG_W-1:0]),
    .copWrEn      (copWrEn),
    .copAddr      (copAddr),
    .copFlagBits  (copWrData[FLAG_W-1:0]),
    .stb          (stb)
  );

  ipc_datapath #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostWrData (hostWrData),
    .copWrData  (copWrData),
    .hostAddr   (hostAddr),
    .copAddr    (copAddr),
    .hostRdData (hostRdData),
    .copRdData  (copRdData),
    .hostIrq    (hostIrq),
    .copIrq     (copIrq)
  );
endmodule

// File: tb/ipc_doorbell_test.sv
module ipc_doorbell_test;
  localparam int CLK_PERIOD = 10;
  localparam int RAND_VECS  = 3000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, copWrEn = 1'b0;
  logic [1:0]  hostAddr = '0, copAddr = '0;
  logic [31:0] hostWrData = '0, copWrData = '0;
  logic [31:0] hostRdData, copRdData;
  logic        copIrq, hostIrq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the register state
  logic [31:0] mHostMsg = '0, mCopMsg = '0;
  logic mBell = 0, mAck = 0, mReply = 0, mReplyEn = 0, mAckEn = 0;
  logic [31:0] seed = 32'h1ACE_B00C;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_doorbell uut (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .copWrEn(copWrEn), .copAddr(copAddr), .copWrData(copWrData), .copRdData(copRdData),
    .copIrq(copIrq), .hostIrq(hostIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mStatus();
    return {26'd0, mAckEn, mReplyEn, 1'b0, mReply, mAck, mBell}; // R10 layout
  endfunction

  function automatic logic [31:0] mRead(input logic [1:0] idx);
    case (idx)
      2'd0: return mHostMsg;
      2'd2: return mCopMsg;
      default: return mStatus();
    endcase
  endfunction

  function automatic string readTag(input logic [1:0] idx);
    case (idx)
      2'd0: return "R2";
      2'd2: return "R3";
      default: return "R10";
    endcase
  endfunction

  // one cycle: drive at falling edge, check pre-edge state, update model at rising edge
  task automatic apply(input logic hE, input logic [1:0] hA, input logic [31:0] hD,
                       input logic cE, input logic [1:0] cA, input logic [31:0] cD);
    logic hs, cs, nBell, nAck, nReply;
    hostWrEn = hE; hostAddr = hA; hostWrData = hD;
    copWrEn  = cE; copAddr  = cA; copWrData  = cD;
    #1;
    check(readTag(hA), hostRdData, mRead(hA));
    check(readTag(cA), copRdData, mRead(cA));
    check("R4", {31'd0, copIrq}, {31'd0, mBell});
    check("R8", {31'd0, hostIrq}, {31'd0, (mReply && mReplyEn) || (mAck && mAckEn)});
    hs = hE && (hA == 2'd1);
    cs = cE && (cA == 2'd3);
    nBell  = (hs && hD[0]) ? 1'b1 : (cs && cD[0]) ? 1'b0 : mBell;  // R4 R5 R9
    nAck   = (cs && cD[1]) ? 1'b1 : (hs && hD[1]) ? 1'b0 : mAck;   // R6 R7 R9
    nReply = (cs && cD[2]) ? 1'b1 : (hs && hD[2]) ? 1'b0 : mReply;
    @(posedge clk);
    if (hE && hA == 2'd0) mHostMsg = hD & 32'hFFFF_FFE0;
    if (cE && cA == 2'd2) mCopMsg  = cD & 32'hFFFF_FFE0;
    if (hs) begin mReplyEn = hD[4]; mAckEn = hD[5]; end
    mBell = nBell; mAck = nAck; mReply = nReply;
    @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] hA, input logic [1:0] cA);
    hostWrEn = 0; copWrEn = 0; hostAddr = hA; copAddr = cA;
    #1;
  endtask

  function automatic logic [31:0] nextRand(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state on every index from both ports
    for (int i = 0; i < 4; i++) begin
      peek(2'(i), 2'(3 - i));
      check("R1", hostRdData, 32'd0);
      check("R1", copRdData, 32'd0);
    end
    check("R1", {30'd0, hostIrq, copIrq}, 32'd0);

    apply(1, 2'd0, 32'h1234_567F, 0, 2'd0, 32'd0);
    peek(2'd0, 2'd0);
    check("R2", hostRdData, 32'h1234_5660);
    check("R2", copRdData, 32'h1234_5660);

    apply(1, 2'd2, 32'hFFFF_FFFF, 1, 2'd0, 32'hFFFF_FFFF);
    apply(1, 2'd3, 32'h0000_0037, 1, 2'd1, 32'h0000_0037);
    peek(2'd0, 2'd2);
    check("R11", hostRdData, 32'h1234_5660);
    check("R11", copRdData, 32'd0);
    peek(2'd1, 2'd3);
    check("R11", hostRdData, 32'd0);

    apply(1, 2'd1, 32'h0000_0031, 0, 2'd0, 32'd0);
    peek(2'd1, 2'd3);
    check("R4", {31'd0, copIrq}, 32'd1);
    check("R10", copRdData, 32'h0000_0031);

    apply(0, 2'd0, 32'd0, 1, 2'd3, 32'h0000_0002);
    peek(2'd1, 2'd3);
    check("R6", hostRdData, 32'h0000_0033);
    check("R8", {31'd0, hostIrq}, 32'd1);

    apply(0, 2'd0, 32'd0, 1, 2'd3, 32'h0000_0001);
    peek(2'd1, 2'd3);
    check("R5", {31'd0, copIrq}, 32'd0);
    check("R5", hostRdData, 32'h0000_0032);

    apply(1, 2'd1, 32'h0000_0032, 0, 2'd0, 32'd0);
    peek(2'd1, 2'd3);
    check("R7", hostRdData, 32'h0000_0030);
    check("R7", {31'd0, hostIrq}, 32'd0);

    apply(0, 2'd0, 32'd0, 1, 2'd2, 32'hABCD_EF1F);
    apply(0, 2'd0, 32'd0, 1, 2'd3, 32'h0000_0004);
    peek(2'd2, 2'd1);
    check("R3", hostRdData, 32'hABCD_EF00);
    check("R6", copRdData, 32'h0000_0034);
    check("R8", {31'd0, hostIrq}, 32'd1);

    apply(1, 2'd1, 32'h0000_0000, 0, 2'd0, 32'd0);
    peek(2'd1, 2'd1);
    check("R8", {31'd0, hostIrq}, 32'd0);
    check("R7", hostRdData, 32'h0000_0004);

    apply(1, 2'd1, 32'h0000_0004, 1, 2'd3, 32'h0000_0004);
    peek(2'd1, 2'd1);
    check("R9", hostRdData, 32'h0000_0004);
    apply(1, 2'd1, 32'h0000_0001, 1, 2'd3, 32'h0000_0001);
    peek(2'd1, 2'd1);
    check("R9", hostRdData, 32'h0000_0005);
    check("R9", {31'd0, copIrq}, 32'd1);

    // pseudo-random sweep over indices, flag bits and data from both sides
    for (int v = 0; v < RAND_VECS; v++) begin
      logic [31:0] a, b, c;
      seed = nextRand(seed); a = seed;
      seed = nextRand(seed); b = seed;
      seed = nextRand(seed); c = seed;
      apply(a[0], a[2:1], b, a[8], a[10:9], c);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule